// File: doc/BRIEF.md
# Descriptor-Chained Cyclic DMA Channel

This block is one DMA channel that copies 32-bit words between two addresses, usually a memory buffer and a fixed peripheral data port. Software programs the channel either directly, by writing the byte count and the two addresses and then enabling the channel, or through descriptors. A descriptor is four words in memory, 16-byte aligned: byte count, source, destination and next pointer. When software writes the fetch command, the channel reads the descriptor that the next-pointer register names. With chain mode on, each descriptor that finishes makes the channel load the one after it. A ring of descriptors whose last entry points back to the first therefore makes the channel loop over a set of periods for as long as it stays enabled.

The channel moves data in bursts. It reads up to a burst's worth of words into a local buffer, then writes them out. Either side can step its address by four after each word, or hold it fixed. When a descriptor's byte count reaches zero, a completion status bit is set and, if unmasked, the interrupt output rises. Clearing the enable bit pauses the channel at the next burst boundary. The abort command stops it at the next word boundary, with no completion.

The controller is a single state machine. Its states are IDLE, FETCH (four descriptor reads), SETUP (burst planning), READ, WRITE, DONE and PAUSE. Its transitions are:
- start-fetch: IDLE to FETCH.
- start-direct: IDLE to SETUP.
- descriptor-loaded: FETCH to SETUP.
- burst-go: SETUP to READ.
- count-zero: SETUP to DONE.
- pause-hold: SETUP to PAUSE.
- burst-full: READ to WRITE.
- burst-drained: WRITE to SETUP.
- chain-next: DONE to FETCH.
- stop: DONE to IDLE.
- resume: PAUSE to SETUP.
- abort: any busy state to IDLE.

Top module: `cdma_channel`

## Requirements
- R1: After reset, every register reads zero, `irq` is low and `mem_req` is low.
- R2: The registers are at these offsets:
  - byte count at 0x00 (17 bits; bits 1:0 always read zero).
  - source at 0x10 and destination at 0x20.
  - next pointer at 0x30 (bits 3:0 always read zero).
  - control at 0x40.
  - priority at 0x60 (plain 32-bit storage).
  - current-descriptor at 0x70 (read-only).
  - interrupt mask at 0x80 and interrupt status at 0xA0.
- R3: Control bits 3:2 set the source step and bits 5:4 set the destination step. Code 2'b10 holds that address fixed. Any other code adds 4 after each word moved on that side.
- R4: Control bits 8:6 set the burst length: 000=1 word, 001=2, 011=4, 110=8, 111=16, 101=32, and other codes give 1 word. Each burst reads min(burst length, remaining words) words, then writes the same number.
- R5: Writing 1 to control bit 13 while bit 12 is set has the following effect:
  - The channel reads the four words at the next pointer plus 0, 4, 8 and 12.
  - It loads them into byte count, source, destination and next pointer, in that order, with the next pointer's low 4 bits cleared.
  - The current-descriptor register takes the descriptor's address.
  - Bit 13 reads back 1 until the fetch starts.
- R6: Status bit 0 is set when the byte count reaches zero. `irq` equals status bit 0 AND mask bit 0. Writing 1 to status bit 0 clears it.
- R7: With control bit 9 (chain) set, a finished descriptor makes the channel fetch the descriptor at the next pointer and continue. With bit 9 clear, the channel stops and control bit 14 (active, read-only) drops.
- R8: Clearing control bit 12 during a transfer halts memory traffic at the next burst boundary, and bit 14 stays set. Setting bit 12 again resumes from the current addresses and count, and no data is lost.
- R9: Writing 1 to control bit 20 stops the channel at the next word boundary. It clears bits 12 and 14 and does not set status bit 0.
- R10: Setting bit 12 with a nonzero byte count and no fetch pending runs the transfer straight from the register values.
- R11: The channel holds `mem_req` with a stable `mem_addr`, `mem_we` and `mem_wdata` until `mem_ready` is high. A word moves on each cycle in which both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts/returns the word this cycle |
| mem_rdata | input | 32 | Memory read data, valid with mem_ready |
| irq | output | 1 | Completion interrupt |

## Verification
The bench targets the following corner cases:
- Burst grouping: it records the read/write order of every beat, so a design that interleaves reads with writes, or ignores the remaining-word limit on the last burst, shows a wrong pattern.
- Descriptor ring: the bench compares the order of words reaching a fixed peripheral address. A channel that failed to reload the source on each descriptor, or that stopped after one descriptor, sends the wrong sequence.
- Pause under memory wait states: the bench checks that traffic truly stops and that every word still arrives. A design that pauses mid-burst would drop or duplicate a word.
- Abort: the bench checks that no completion is flagged and that the tail of the buffer stays untouched.

// File: rtl/cdma_pkg.sv
package cdma_pkg;

    localparam logic [7:0] OFS_CNT  = 8'h00;
    localparam logic [7:0] OFS_SRC  = 8'h10;
    localparam logic [7:0] OFS_DST  = 8'h20;
    localparam logic [7:0] OFS_NXT  = 8'h30;
    localparam logic [7:0] OFS_CTL  = 8'h40;
    localparam logic [7:0] OFS_PRIO = 8'h60;
    localparam logic [7:0] OFS_CUR  = 8'h70;
    localparam logic [7:0] OFS_MASK = 8'h80;
    localparam logic [7:0] OFS_STS  = 8'hA0;

    localparam int CTL_EN    = 12;
    localparam int CTL_FETCH = 13;
    localparam int CTL_ACT   = 14;
    localparam int CTL_ABORT = 20;
    localparam int CTL_CHAIN = 9;

    localparam logic [1:0] STEP_HOLD = 2'b10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_SETUP,
        ST_READ,
        ST_WRITE,
        ST_DONE,
        ST_PAUSE
    } cdma_state_e;

    function automatic logic [6:0] burst_words(input logic [2:0] code);
        unique case (code)
            3'b000:  burst_words = 7'd1;
            3'b001:  burst_words = 7'd2;
            3'b011:  burst_words = 7'd4;
            3'b110:  burst_words = 7'd8;
            3'b111:  burst_words = 7'd16;
            3'b101:  burst_words = 7'd32;
            default: burst_words = 7'd1;
        endcase
    endfunction

endpackage

// File: rtl/cdma_beat_buf.sv
module cdma_beat_buf #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data = store_q[rd_idx];

endmodule

// File: rtl/cdma_engine.sv
module cdma_engine
    import cdma_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 17,
    parameter int BUF_DEPTH = 32,
    localparam int IDX_W    = $clog2(BUF_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              chain_i,
    input  logic [2:0]        burst_i,
    input  logic              fetch_pend_i,
    input  logic              abort_pend_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [ADDR_W-1:0] src_i,
    input  logic [ADDR_W-1:0] dst_i,
    input  logic [ADDR_W-5:0] nxt_blk_i,
    input  logic              mem_ready_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              buf_we_o,
    output logic [IDX_W-1:0]  beat_idx_o,
    output logic              active_o,
    output logic              fetch_take_o,
    output logic              cur_ld_o,
    output logic              desc_ld_o,
    output logic [1:0]        desc_sel_o,
    output logic              src_step_o,
    output logic              dst_step_o,
    output logic              cnt_dec_o,
    output logic              done_o,
    output logic              abort_done_o
);

    cdma_state_e      state_q, state_d;
    logic [1:0]       word_q, word_d;
    logic [IDX_W-1:0] beat_q, beat_d;
    logic [IDX_W:0]   blen_q, blen_d;
    logic [IDX_W:0]   beat_nx;
    logic             last_beat;
    logic             xfer;
    logic [CNT_W-1:0] bw_full, wc_full, plan_full;

    assign xfer      = mem_req_o && mem_ready_i;
    assign beat_nx   = {1'b0, beat_q} + 1'b1;
    assign last_beat = (beat_nx == blen_q);

    // burst planning: min(burst code length, buffer depth, words left)
    always_comb begin
        bw_full = CNT_W'(burst_words(burst_i));
        if (bw_full > CNT_W'(BUF_DEPTH)) begin
            bw_full = CNT_W'(BUF_DEPTH);
        end
        wc_full   = cnt_i >> 2;
        plan_full = (wc_full < bw_full) ? wc_full : bw_full;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            word_q  <= '0;
            beat_q  <= '0;
            blen_q  <= '0;
        end else begin
            state_q <= state_d;
            word_q  <= word_d;
            beat_q  <= beat_d;
            blen_q  <= blen_d;
        end
    end

    always_comb begin
        state_d      = state_q;
        word_d       = word_q;
        beat_d       = beat_q;
        blen_d       = blen_q;
        mem_req_o    = 1'b0;
        mem_we_o     = 1'b0;
        mem_addr_o   = '0;
        buf_we_o     = 1'b0;
        fetch_take_o = 1'b0;
        cur_ld_o     = 1'b0;
        desc_ld_o    = 1'b0;
        desc_sel_o   = word_q;
        src_step_o   = 1'b0;
        dst_step_o   = 1'b0;
        cnt_dec_o    = 1'b0;
        done_o       = 1'b0;
        abort_done_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (abort_pend_i) begin
                    abort_done_o = 1'b1;
                end else if (en_i && fetch_pend_i) begin
                    fetch_take_o = 1'b1;
                    cur_ld_o     = 1'b1;
                    word_d       = '0;
                    state_d      = ST_FETCH;
                end else if (en_i && (cnt_i != '0)) begin
                    state_d = ST_SETUP;
                end
            end
            ST_FETCH: begin
                mem_req_o  = 1'b1;
                mem_addr_o = {nxt_blk_i, word_q, 2'b00};
                if (xfer) begin
                    desc_ld_o = 1'b1;
                    if (abort_pend_i) begin
                        abort_done_o = 1'b1;
                        state_d      = ST_IDLE;
                    end else if (word_q == 2'd3) begin
                        state_d = ST_SETUP;
                    end else begin
                        word_d = word_q + 2'd1;
                    end
                end
            end
            ST_SETUP: begin
                if (abort_pend_i) begin
                    abort_done_o = 1'b1;
                    state_d      = ST_IDLE;
                end else if (cnt_i == '0) begin
                    state_d = ST_DONE;
                end else if (!en_i) begin
                    state_d = ST_PAUSE;
                end else begin
                    blen_d  = (IDX_W+1)'(plan_full);
                    beat_d  = '0;
                    state_d = ST_READ;
                end
            end
            ST_READ: begin
                mem_req_o  = 1'b1;
                mem_addr_o = src_i;
                if (xfer) begin
                    buf_we_o   = 1'b1;
                    src_step_o = 1'b1;
                    if (abort_pend_i) begin
                        abort_done_o = 1'b1;
                        state_d      = ST_IDLE;
                    end else if (last_beat) begin
                        beat_d  = '0;
                        state_d = ST_WRITE;
                    end else begin
                        beat_d = beat_nx[IDX_W-1:0];
                    end
                end
            end
            ST_WRITE: begin
                mem_req_o  = 1'b1;
                mem_we_o   = 1'b1;
                mem_addr_o = dst_i;
                if (xfer) begin
                    dst_step_o = 1'b1;
                    cnt_dec_o  = 1'b1;
                    if (abort_pend_i) begin
                        abort_done_o = 1'b1;
                        state_d      = ST_IDLE;
                    end else if (last_beat) begin
                        state_d = ST_SETUP;
                    end else begin
                        beat_d = beat_nx[IDX_W-1:0];
                    end
                end
            end
            ST_DONE: begin
                if (abort_pend_i) begin
                    abort_done_o = 1'b1;
                    state_d      = ST_IDLE;
                end else begin
                    done_o = 1'b1;
                    if (chain_i) begin
                        cur_ld_o = 1'b1;
                        word_d   = '0;
                        state_d  = ST_FETCH;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_PAUSE: begin
                if (abort_pend_i) begin
                    abort_done_o = 1'b1;
                    state_d      = ST_IDLE;
                end else if (en_i) begin
                    state_d = ST_SETUP;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign active_o   = (state_q != ST_IDLE);
    assign beat_idx_o = beat_q;

    // R11: a pending request keeps its command until accepted
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

    // R4: beat index never runs past the planned burst
    assert_beat_in_burst_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ || state_q == ST_WRITE) |-> ({1'b0, beat_q} < blen_q));

    // R7: without chain the channel goes inactive after completion
    assert_stop_unchained_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !chain_i) |=> !active_o);

endmodule

// File: rtl/cdma_channel.sv
module cdma_channel
    import cdma_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 17,
    parameter int BUF_DEPTH = 32,
    localparam int IDX_W    = $clog2(BUF_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ready,
    input  logic [31:0]       mem_rdata,
    output logic              irq
);

    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] src_q, dst_q, nxt_q, cur_q;
    logic [31:0]       prio_q;
    logic              mask_q, sts_q;
    logic              en_q, chain_q, fetch_q, abort_q;
    logic [2:0]        burst_q, ssz_q;
    logic [1:0]        sstep_q, dstep_q;

    logic              active, buf_we, fetch_take, cur_ld, desc_ld;
    logic [1:0]        desc_sel;
    logic              src_step, dst_step, cnt_dec, done, abort_done;
    logic [IDX_W-1:0]  beat_idx;

    cdma_engine #(
        .ADDR_W   (ADDR_W),
        .CNT_W    (CNT_W),
        .BUF_DEPTH(BUF_DEPTH)
    ) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en_q),
        .chain_i     (chain_q),
        .burst_i     (burst_q),
        .fetch_pend_i(fetch_q),
        .abort_pend_i(abort_q),
        .cnt_i       (cnt_q),
        .src_i       (src_q),
        .dst_i       (dst_q),
        .nxt_blk_i   (nxt_q[ADDR_W-1:4]),
        .mem_ready_i (mem_ready),
        .mem_req_o   (mem_req),
        .mem_we_o    (mem_we),
        .mem_addr_o  (mem_addr),
        .buf_we_o    (buf_we),
        .beat_idx_o  (beat_idx),
        .active_o    (active),
        .fetch_take_o(fetch_take),
        .cur_ld_o    (cur_ld),
        .desc_ld_o   (desc_ld),
        .desc_sel_o  (desc_sel),
        .src_step_o  (src_step),
        .dst_step_o  (dst_step),
        .cnt_dec_o   (cnt_dec),
        .done_o      (done),
        .abort_done_o(abort_done)
    );

    cdma_beat_buf #(
        .DEPTH(BUF_DEPTH),
        .WIDTH(32)
    ) u_buf (
        .clk    (clk),
        .wr_en  (buf_we),
        .wr_idx (beat_idx),
        .wr_data(mem_rdata),
        .rd_idx (beat_idx),
        .rd_data(mem_wdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            src_q   <= '0;
            dst_q   <= '0;
            nxt_q   <= '0;
            cur_q   <= '0;
            prio_q  <= '0;
            mask_q  <= 1'b0;
            sts_q   <= 1'b0;
            en_q    <= 1'b0;
            chain_q <= 1'b0;
            fetch_q <= 1'b0;
            abort_q <= 1'b0;
            burst_q <= '0;
            ssz_q   <= '0;
            sstep_q <= '0;
            dstep_q <= '0;
        end else begin
            // software side
            if (reg_wr) begin
                unique case (reg_addr)
                    OFS_CNT:  cnt_q  <= {reg_wdata[CNT_W-1:2], 2'b00};
                    OFS_SRC:  src_q  <= ADDR_W'(reg_wdata);
                    OFS_DST:  dst_q  <= ADDR_W'(reg_wdata);
                    OFS_NXT:  nxt_q  <= {reg_wdata[ADDR_W-1:4], 4'h0};
                    OFS_PRIO: prio_q <= reg_wdata;
                    OFS_MASK: mask_q <= reg_wdata[0];
                    OFS_STS:  if (reg_wdata[0]) sts_q <= 1'b0;
                    OFS_CTL: begin
                        en_q    <= reg_wdata[CTL_EN];
                        chain_q <= reg_wdata[CTL_CHAIN];
                        ssz_q   <= reg_wdata[24:22];
                        burst_q <= reg_wdata[8:6];
                        dstep_q <= reg_wdata[5:4];
                        sstep_q <= reg_wdata[3:2];
                        if (reg_wdata[CTL_FETCH]) fetch_q <= 1'b1;
                        if (reg_wdata[CTL_ABORT]) abort_q <= 1'b1;
                    end
                    default: ;
                endcase
            end
            // engine side, takes precedence
            if (fetch_take) fetch_q <= 1'b0;
            if (cur_ld) cur_q <= nxt_q;
            if (desc_ld) begin
                unique case (desc_sel)
                    2'd0: cnt_q <= {mem_rdata[CNT_W-1:2], 2'b00};
                    2'd1: src_q <= ADDR_W'(mem_rdata);
                    2'd2: dst_q <= ADDR_W'(mem_rdata);
                    2'd3: nxt_q <= {mem_rdata[ADDR_W-1:4], 4'h0};
                    default: ;
                endcase
            end
            if (src_step && sstep_q != STEP_HOLD) src_q <= src_q + ADDR_W'(4);
            if (dst_step && dstep_q != STEP_HOLD) dst_q <= dst_q + ADDR_W'(4);
            if (cnt_dec) cnt_q <= cnt_q - CNT_W'(4);
            if (done) sts_q <= 1'b1;
            if (abort_done) begin
                en_q    <= 1'b0;
                abort_q <= 1'b0;
                fetch_q <= 1'b0;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_CNT:  reg_rdata = 32'(cnt_q);
            OFS_SRC:  reg_rdata = 32'(src_q);
            OFS_DST:  reg_rdata = 32'(dst_q);
            OFS_NXT:  reg_rdata = 32'(nxt_q);
            OFS_PRIO: reg_rdata = prio_q;
            OFS_CUR:  reg_rdata = 32'(cur_q);
            OFS_MASK: reg_rdata = {31'd0, mask_q};
            OFS_STS:  reg_rdata = {31'd0, sts_q};
            OFS_CTL: begin
                reg_rdata[24:22]     = ssz_q;
                reg_rdata[CTL_ACT]   = active;
                reg_rdata[CTL_FETCH] = fetch_q;
                reg_rdata[CTL_EN]    = en_q;
                reg_rdata[CTL_CHAIN] = chain_q;
                reg_rdata[8:6]       = burst_q;
                reg_rdata[5:4]       = dstep_q;
                reg_rdata[3:2]       = sstep_q;
            end
            default: reg_rdata = '0;
        endcase
    end

    assign irq = sts_q & mask_q;

    // R9: abort leaves the channel disabled and idle
    assert_abort_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        abort_done |=> (!en_q && !active));

    // R6: completion is recorded in the status bit
    assert_done_sets_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> sts_q);

    // R3: a held source side keeps its address across beats
    assert_src_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (src_step && sstep_q == STEP_HOLD && !desc_ld && !(reg_wr && reg_addr == OFS_SRC))
        |=> $stable(src_q));

endmodule

// File: tb/test_cdma_channel.sv
`timescale 1ns/1ps
module test_cdma_channel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, mem_ready;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        irq;

    int n_checks = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    cdma_channel i_cdma_channel (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .irq(irq)
    );

    // memory model
    logic [31:0] mem [1024];
    logic        wait_mode = 1'b0;
    logic        rdy_tog = 1'b0;
    logic        poke_en = 1'b0;
    logic [31:0] poke_a = '0, poke_d = '0;
    logic        log_clr = 1'b0;
    int          wr_cnt = 0, beat_cnt = 0;
    logic [63:0] we_vec = '0;
    logic [31:0] wr_data [64];

    assign mem_ready = wait_mode ? rdy_tog : 1'b1;
    assign mem_rdata = mem[mem_addr[11:2]];

    always @(posedge clk) begin
        rdy_tog <= ~rdy_tog;
        if (poke_en) mem[poke_a[11:2]] <= poke_d;
        else if (mem_req && mem_we && mem_ready) mem[mem_addr[11:2]] <= mem_wdata;
    end

    always @(posedge clk) begin
        if (log_clr) begin
            wr_cnt <= 0; beat_cnt <= 0; we_vec <= '0;
        end else if (mem_req && mem_ready) begin
            if (beat_cnt < 64) we_vec[beat_cnt] <= mem_we;
            beat_cnt <= beat_cnt + 1;
            if (mem_we) begin
                if (wr_cnt < 64) wr_data[wr_cnt] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end
        end
    end

    localparam logic [1:0] INC = 2'b00, HOLD = 2'b10;

    function automatic logic [31:0] cw(input bit en, input bit chain, input logic [2:0] burst,
                                       input logic [1:0] dd, input logic [1:0] sd,
                                       input bit fetch, input bit abrt);
        logic [31:0] v;
        v = '0;
        v[12] = en; v[9] = chain; v[8:6] = burst; v[5:4] = dd; v[3:2] = sd;
        v[13] = fetch; v[20] = abrt;
        return v;
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        poke_en = 1'b1; poke_a = a; poke_d = d;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic clear_log();
        @(negedge clk); log_clr = 1'b1;
        @(negedge clk); log_clr = 1'b0;
    endtask

    task automatic wait_inactive();
        logic [31:0] v;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 20000; i++) begin
            rd(8'h40, v);
            if (!v[14]) break;
        end
    endtask

    task automatic wait_writes(input int n);
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (wr_cnt >= n) break;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(8'h40, v); check("R1", "ctl after reset", v, 32'h0);
        rd(8'hA0, v); check("R1", "status after reset", v, 32'h0);
        rd(8'h00, v); check("R1", "count after reset", v, 32'h0);
        rd(8'h70, v); check("R1", "cur after reset", v, 32'h0);
        check("R1", "irq/mem_req after reset", {30'd0, irq, mem_req}, 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(8'h10, 32'h1234_5678); rd(8'h10, v); check("R2", "src readback", v, 32'h1234_5678);
        wr(8'h20, 32'h0000_0ABC); rd(8'h20, v); check("R2", "dst readback", v, 32'h0000_0ABC);
        wr(8'h60, 32'hA5A5_0003); rd(8'h60, v); check("R2", "prio readback", v, 32'hA5A5_0003);
        wr(8'h30, 32'h0000_013F); rd(8'h30, v); check("R2", "next ptr aligned", v, 32'h0000_0130);
        wr(8'h00, 32'h0001_0003); rd(8'h00, v); check("R2", "count word granular", v, 32'h0001_0000);
        wr(8'h70, 32'h0000_FFFF); rd(8'h70, v); check("R2", "cur read-only", v, 32'h0);
        wr(8'h80, 32'h1); rd(8'h80, v); check("R2", "mask readback", v, 32'h1);
    endtask

    task automatic t_direct_hold();
        logic [31:0] v;
        wr(8'h40, cw(0, 0, 3'b000, HOLD, INC, 0, 0));
        for (int i = 0; i < 4; i++) poke(32'h100 + 4 * i, 32'hA000_0000 + i);
        poke(32'h800, 0); poke(32'h804, 0);
        wr(8'h00, 16); wr(8'h10, 32'h100); wr(8'h20, 32'h800);
        wr(8'h40, cw(1, 0, 3'b000, HOLD, INC, 0, 0));
        wait_inactive();
        check("R10", "direct run last word at held dst", mem[32'h800 >> 2], 32'hA000_0003);
        check("R3", "held dst neighbour untouched", mem[32'h804 >> 2], 32'h0);
        rd(8'h10, v); check("R3", "src incremented", v, 32'h110);
        rd(8'h20, v); check("R3", "dst held", v, 32'h800);
        rd(8'h00, v); check("R10", "count zero", v, 32'h0);
        rd(8'hA0, v); check("R6", "status set", v, 32'h1);
        check("R6", "irq with mask", {31'd0, irq}, 32'h1);
        wr(8'hA0, 32'h1);
        rd(8'hA0, v); check("R6", "status W1C", v, 32'h0);
        check("R6", "irq cleared", {31'd0, irq}, 32'h0);
    endtask

    task automatic t_burst();
        logic [31:0] v;
        wr(8'h40, cw(0, 0, 3'b011, INC, INC, 0, 0));
        wr(8'h80, 32'h0);
        for (int i = 0; i < 8; i++) poke(32'h200 + 4 * i, 32'hB000_0000 + i);
        wr(8'h00, 32); wr(8'h10, 32'h200); wr(8'h20, 32'h300);
        clear_log();
        wr(8'h40, cw(1, 0, 3'b011, INC, INC, 0, 0));
        wait_inactive();
        check("R4", "4-word burst beat count", beat_cnt, 16);
        check("R4", "4-word burst pattern", {16'd0, we_vec[15:0]}, 32'h0000_F0F0);
        for (int i = 0; i < 8; i++)
            check("R4", "burst copy word", mem[(32'h300 >> 2) + i], 32'hB000_0000 + i);
        rd(8'hA0, v); check("R6", "status set while masked", v, 32'h1);
        check("R6", "irq masked", {31'd0, irq}, 32'h0);
        wr(8'hA0, 32'h1);
        // long burst code clipped by remaining words
        wr(8'h40, cw(0, 0, 3'b101, INC, INC, 0, 0));
        wr(8'h00, 24); wr(8'h10, 32'h200); wr(8'h20, 32'h380);
        clear_log();
        wr(8'h40, cw(1, 0, 3'b101, INC, INC, 0, 0));
        wait_inactive();
        check("R4", "clipped burst beat count", beat_cnt, 12);
        check("R4", "clipped burst pattern", {20'd0, we_vec[11:0]}, 32'h0000_0FC0);
        check("R4", "clipped burst last word", mem[(32'h380 >> 2) + 5], 32'hB000_0005);
        wr(8'hA0, 32'h1);
    endtask

    task automatic t_fetch_single();
        logic [31:0] v;
        wr(8'h40, cw(0, 0, 3'b000, INC, INC, 0, 0));
        poke(32'h60, 8); poke(32'h64, 32'h400); poke(32'h68, 32'h480); poke(32'h6C, 32'h7C);
        poke(32'h400, 32'hC000_0001); poke(32'h404, 32'hC000_0002);
        wr(8'h30, 32'h60);
        wr(8'h40, cw(1, 0, 3'b000, INC, INC, 1, 0));
        wait_inactive();
        rd(8'h70, v); check("R5", "cur = descriptor addr", v, 32'h60);
        rd(8'h30, v); check("R5", "next loaded and aligned", v, 32'h70);
        rd(8'h10, v); check("R5", "src from descriptor", v, 32'h408);
        rd(8'h20, v); check("R5", "dst from descriptor", v, 32'h488);
        check("R5", "descriptor data word", mem[(32'h480 >> 2) + 1], 32'hC000_0002);
        rd(8'h40, v); check("R7", "unchained stop: active/fetch low", {30'd0, v[14], v[13]}, 32'h0);
        rd(8'hA0, v); check("R6", "status after descriptor", v, 32'h1);
        wr(8'hA0, 32'h1);
    endtask

    task automatic t_ring();
        logic [31:0] v;
        wr(8'h40, cw(0, 1, 3'b000, HOLD, INC, 0, 0));
        poke(32'h20, 8); poke(32'h24, 32'h500); poke(32'h28, 32'h900); poke(32'h2C, 32'h30);
        poke(32'h30, 8); poke(32'h34, 32'h600); poke(32'h38, 32'h900); poke(32'h3C, 32'h20);
        poke(32'h500, 32'hD0A0); poke(32'h504, 32'hD0A1);
        poke(32'h600, 32'hD0B0); poke(32'h604, 32'hD0B1);
        wr(8'h30, 32'h20);
        clear_log();
        wr(8'h40, cw(1, 1, 3'b000, HOLD, INC, 1, 0));
        wait_writes(6);
        wr(8'h40, cw(1, 1, 3'b000, HOLD, INC, 0, 1));
        repeat (10) @(negedge clk);
        check("R7", "ring word 0", wr_data[0], 32'hD0A0);
        check("R7", "ring word 1", wr_data[1], 32'hD0A1);
        check("R7", "ring word 2", wr_data[2], 32'hD0B0);
        check("R7", "ring word 3", wr_data[3], 32'hD0B1);
        check("R7", "ring wraps word 4", wr_data[4], 32'hD0A0);
        check("R7", "ring wraps word 5", wr_data[5], 32'hD0A1);
        rd(8'h40, v); check("R9", "abort clears enable/active", {30'd0, v[14], v[12]}, 32'h0);
        wr(8'hA0, 32'h1);
    endtask

    task automatic t_pause();
        logic [31:0] v;
        int frozen;
        wr(8'h40, cw(0, 0, 3'b000, INC, INC, 0, 0));
        for (int i = 0; i < 16; i++) poke(32'h700 + 4 * i, 32'hE000_0000 + i);
        wr(8'h00, 64); wr(8'h10, 32'h700); wr(8'h20, 32'hA00);
        @(negedge clk); wait_mode = 1'b1;
        clear_log();
        wr(8'h40, cw(1, 0, 3'b000, INC, INC, 0, 0));
        wait_writes(5);
        wr(8'h40, cw(0, 0, 3'b000, INC, INC, 0, 0));
        repeat (10) @(negedge clk);
        frozen = wr_cnt;
        repeat (30) @(negedge clk);
        check("R8", "no writes while paused", wr_cnt, frozen);
        check("R8", "no request while paused", {31'd0, mem_req}, 32'h0);
        rd(8'h40, v); check("R8", "active held while paused", {31'd0, v[14]}, 32'h1);
        wr(8'h40, cw(1, 0, 3'b000, INC, INC, 0, 0));
        wait_inactive();
        check("R8", "total writes after resume", wr_cnt, 16);
        for (int i = 0; i < 16; i++)
            check("R11", "copy under wait states", mem[(32'hA00 >> 2) + i], 32'hE000_0000 + i);
        @(negedge clk); wait_mode = 1'b0;
        wr(8'hA0, 32'h1);
    endtask

    task automatic t_abort();
        logic [31:0] v;
        wr(8'h40, cw(0, 0, 3'b000, INC, INC, 0, 0));
        wr(8'hA0, 32'h1);
        wr(8'h80, 32'h1);
        poke(32'hB3C, 32'h0);
        wr(8'h00, 64); wr(8'h10, 32'h700); wr(8'h20, 32'hB00);
        clear_log();
        wr(8'h40, cw(1, 0, 3'b000, INC, INC, 0, 0));
        wait_writes(3);
        wr(8'h40, cw(1, 0, 3'b000, INC, INC, 0, 1));
        repeat (10) @(negedge clk);
        rd(8'h40, v); check("R9", "abort: enable/active low", {30'd0, v[14], v[12]}, 32'h0);
        rd(8'hA0, v); check("R9", "abort: no completion", v, 32'h0);
        check("R9", "abort: irq low", {31'd0, irq}, 32'h0);
        check("R9", "abort: tail untouched", mem[32'hB3C >> 2], 32'h0);
        check("R9", "abort: no request", {31'd0, mem_req}, 32'h0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog timeout");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_direct_hold();
        t_burst();
        t_fetch_single();
        t_ring();
        t_pause();
        t_abort();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule